// File: doc/BRIEF.md
# DRAM Power-Up CKE Sequencer

This block controls a DRAM device's clock-enable line while the memory controller comes out of reset. Once reset is released, it holds CKE low for a programmed number of 1024-cycle units. It then raises CKE and waits a second programmed number of 1024-cycle units. After that it sends a one-cycle start request to a downstream initialization engine. When that engine answers with a done acknowledge, the block reports normal operation.

A two-bit skip code can bypass the whole sequence. The controller then goes straight to normal operation with CKE high, or straight to self-refresh with CKE held low so that external logic can take over the pin. The two wait counts and the skip code are read only once, on the first clock edge after reset is released. Changes on those inputs after that edge have no effect until the next reset.

The reset input is asynchronous and active low. The surrounding logic must release it synchronously to `clk`.

Top module: `cke_powerup_seq`

## Requirements
- R1: While reset is asserted, `cke_o` is 0, `init_start_o` is 0 and `op_state_o` is 2'b00 (power-up in progress).
- R2: `pre_units_i`, `post_units_i` and `skip_mode_i` are sampled only on the first rising clock edge after reset is released. Later changes to them do not alter any output until the next reset.
- R3: With skip code 2'b00 or 2'b10, the full sequence runs and CKE is low for the whole pre-CKE wait.
- R4: The pre-CKE wait lasts N×1024 cycles for a count N > 0, and 1 cycle for N = 0. Counted in falling-edge samples after reset release, CKE is first seen high at sample 1 + wait.
- R5: After CKE rises, the post-CKE wait lasts M×1024 cycles for M > 0, and 1 cycle for M = 0. CKE stays high throughout. `init_start_o` is first seen high at sample 1 + pre wait + post wait.
- R6: `init_start_o` is high for exactly one cycle per sequence, and only while CKE is high.
- R7: `op_state_o` stays 2'b00 until `init_done_i` is sampled high after the start pulse. It becomes 2'b01 (normal) in the next cycle. An `init_done_i` that arrives before or during the start pulse is ignored.
- R8: Skip code 2'b01 gives `op_state_o` = 2'b01 and `cke_o` = 1 from the first cycle after reset release, with no start pulse.
- R9: Skip code 2'b11 gives `op_state_o` = 2'b10 (self-refresh) from the first cycle after reset release. In that state `cke_o` is held at 0 and no start pulse is issued.
- R10: Normal and self-refresh are final states until the next reset. Once CKE has risen it never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pre_units_i | input | PRE_W (12) | Wait before CKE rises, in 1024-cycle units |
| post_units_i | input | POST_W (10) | Wait after CKE rises, in 1024-cycle units |
| skip_mode_i | input | 2 | 00/10 run sequence, 01 start normal, 11 start self-refresh |
| init_done_i | input | 1 | Acknowledge from the initialization engine |
| cke_o | output | 1 | DRAM clock enable |
| init_start_o | output | 1 | One-cycle start request to the initialization engine |
| op_state_o | output | 2 | 00 power-up, 01 normal, 10 self-refresh |

## Verification
The hardest situations to reach from the ports are the prescaler rollover that ends a wait, and a change of the configuration inputs after the sampling edge. Each can only be observed thousands of cycles later, through the timing of the CKE edge and the start pulse. The stimulus therefore uses small counts (0 to 3 units) to reach these boundaries quickly, and runs the default counts once. Right after the sampling edge it rewrites the count and skip inputs to different values and pulses an early acknowledge. A behavioural reference model, built on a per-phase remaining-cycle counter, is compared against the outputs on every clock.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;

  typedef enum logic [2:0] {
    ST_LOAD   = 3'd0,
    ST_PRE    = 3'd1,
    ST_POST   = 3'd2,
    ST_START  = 3'd3,
    ST_WAIT   = 3'd4,
    ST_NORMAL = 3'd5,
    ST_SREF   = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_BOOT   = 2'b00,
    OP_NORMAL = 2'b01,
    OP_SREF   = 2'b10
  } op_mode_e;

  localparam logic [1:0] SKIP_TO_NORMAL = 2'b01;
  localparam logic [1:0] SKIP_TO_SREF   = 2'b11;

endpackage

// File: rtl/cke_unit_timer.sv
module cke_unit_timer #(
  parameter int PRESCALE_W = 10,
  parameter int UNIT_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [UNIT_W-1:0] target_i,
  output logic              done_o
);

  localparam logic [PRESCALE_W-1:0] PS_LAST = '1;
  localparam logic [PRESCALE_W-1:0] PS_ONE  = PRESCALE_W'(1);
  localparam logic [UNIT_W-1:0]     U_ONE   = UNIT_W'(1);

  logic [PRESCALE_W-1:0] ps_q, ps_d;
  logic [UNIT_W-1:0]     unit_q, unit_d;
  logic                  ps_wrap;
  logic                  zero_target;

  assign ps_wrap     = (ps_q == PS_LAST);
  assign zero_target = (target_i == '0);

  // a zero target finishes in the first enabled cycle
  always_comb begin
    done_o = en_i && (zero_target || (ps_wrap && (unit_q == (target_i - U_ONE))));
  end

  always_comb begin
    ps_d   = ps_q;
    unit_d = unit_q;
    if (!en_i || done_o) begin
      ps_d   = '0;
      unit_d = '0;
    end else begin
      ps_d = ps_q + PS_ONE;
      if (ps_wrap) begin
        unit_d = unit_q + U_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      unit_q <= '0;
    end else begin
      ps_q   <= ps_d;
      unit_q <= unit_d;
    end
  end

endmodule

// File: rtl/cke_seq_fsm.sv
module cke_seq_fsm
  import cke_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] skip_i,
  input  logic       wait_done_i,
  input  logic       init_done_i,
  output seq_state_e state_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOAD: begin
        if (skip_i == SKIP_TO_NORMAL)    state_d = ST_NORMAL;
        else if (skip_i == SKIP_TO_SREF) state_d = ST_SREF;
        else                             state_d = ST_PRE;
      end
      ST_PRE:    if (wait_done_i) state_d = ST_POST;
      ST_POST:   if (wait_done_i) state_d = ST_START;
      ST_START:  state_d = ST_WAIT;
      ST_WAIT:   if (init_done_i) state_d = ST_NORMAL;
      ST_NORMAL: state_d = ST_NORMAL;
      ST_SREF:   state_d = ST_SREF;
      default:   state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOAD;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/cke_powerup_seq.sv
module cke_powerup_seq
  import cke_seq_pkg::*;
#(
  parameter int PRE_W      = 12,
  parameter int POST_W     = 10,
  parameter int PRESCALE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  pre_units_i,
  input  logic [POST_W-1:0] post_units_i,
  input  logic [1:0]        skip_mode_i,
  input  logic              init_done_i,
  output logic              cke_o,
  output logic              init_start_o,
  output logic [1:0]        op_state_o
);

  localparam int UNIT_W = (PRE_W > POST_W) ? PRE_W : POST_W;

  seq_state_e        state;
  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic              cfg_en;
  logic [UNIT_W-1:0] pre_ext, post_ext, target;
  logic              timer_en, timer_done;

  // configuration captured once, in the load state only
  assign cfg_en = (state == ST_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (cfg_en) begin
      pre_q  <= pre_units_i;
      post_q <= post_units_i;
    end
  end

  generate
    if (UNIT_W > PRE_W) begin : g_pre_pad
      assign pre_ext = {{(UNIT_W-PRE_W){1'b0}}, pre_q};
    end else begin : g_pre_full
      assign pre_ext = pre_q;
    end
    if (UNIT_W > POST_W) begin : g_post_pad
      assign post_ext = {{(UNIT_W-POST_W){1'b0}}, post_q};
    end else begin : g_post_full
      assign post_ext = post_q;
    end
  endgenerate

  assign timer_en = (state == ST_PRE) || (state == ST_POST);
  assign target   = (state == ST_PRE) ? pre_ext : post_ext;

  cke_unit_timer #(
    .PRESCALE_W(PRESCALE_W),
    .UNIT_W    (UNIT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (timer_en),
    .target_i(target),
    .done_o  (timer_done)
  );

  cke_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .skip_i     (skip_mode_i),
    .wait_done_i(timer_done),
    .init_done_i(init_done_i),
    .state_o    (state)
  );

  always_comb begin
    cke_o        = 1'b0;
    init_start_o = 1'b0;
    op_state_o   = OP_BOOT;
    unique case (state)
      ST_POST, ST_WAIT: cke_o = 1'b1;
      ST_START: begin
        cke_o        = 1'b1;
        init_start_o = 1'b1;
      end
      ST_NORMAL: begin
        cke_o      = 1'b1;
        op_state_o = OP_NORMAL;
      end
      ST_SREF:  op_state_o = OP_SREF;
      default: ;
    endcase
  end

endmodule

// File: rtl/cke_powerup_seq_chk.sv
module cke_powerup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_done_i,
  input logic       cke_o,
  input logic       init_start_o,
  input logic [1:0] op_state_o
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!cke_o && !init_start_o && op_state_o == 2'b00));

  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    init_start_o |=> !init_start_o);

  a_r6_start_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
    init_start_o |-> (cke_o && op_state_o == 2'b00));

  a_r7_normal_has_cke: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state_o == 2'b01) |-> cke_o);

  a_r9_sref_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state_o == 2'b10) |-> (!cke_o && !init_start_o));

  a_r10_normal_final: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state_o == 2'b01) |=> (op_state_o == 2'b01));

  a_r10_sref_final: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state_o == 2'b10) |=> (op_state_o == 2'b10));

  a_r10_cke_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |=> cke_o);

  a_r10_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    op_state_o != 2'b11);

endmodule

bind cke_powerup_seq cke_powerup_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_done_i (init_done_i),
  .cke_o       (cke_o),
  .init_start_o(init_start_o),
  .op_state_o  (op_state_o)
);

// File: tb/cke_powerup_seq_bench.sv
`timescale 1ns/1ps
module cke_powerup_seq_bench;

  logic        clk;
  logic        rst_n;
  logic [11:0] pre_i;
  logic [9:0]  post_i;
  logic [1:0]  skip_i;
  logic        done_i;
  logic        cke, start;
  logic [1:0]  op;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  bit cmp_en = 0;

  cke_powerup_seq u_cke_powerup_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pre_units_i (pre_i),
    .post_units_i(post_i),
    .skip_mode_i (skip_i),
    .init_done_i (done_i),
    .cke_o       (cke),
    .init_start_o(start),
    .op_state_o  (op)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // reference model: phase 0 load,1 pre,2 post,3 start,4 wait,5 normal,6 sref
  int m_phase = 0;
  int m_left  = 0;
  int m_post  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
    end else begin
      case (m_phase)
        0: begin
          m_post = int'(post_i);
          if (skip_i == 2'b01)      m_phase = 5;
          else if (skip_i == 2'b11) m_phase = 6;
          else begin
            m_phase = 1;
            m_left  = (pre_i == 0) ? 1 : int'(pre_i) * 1024;
          end
        end
        1: begin
          m_left--;
          if (m_left == 0) begin
            m_phase = 2;
            m_left  = (m_post == 0) ? 1 : m_post * 1024;
          end
        end
        2: begin
          m_left--;
          if (m_left == 0) m_phase = 3;
        end
        3: m_phase = 4;
        4: if (done_i) m_phase = 5;
        default: ;
      endcase
    end
  end

  function automatic string phase_tag(int p);
    case (p)
      0, 1: return "R3/R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8/R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(phase_tag(m_phase), "cke", int'(cke),
            (m_phase >= 2 && m_phase <= 5) ? 1 : 0);
      check(phase_tag(m_phase), "start", int'(start), (m_phase == 3) ? 1 : 0);
      check(phase_tag(m_phase), "op", int'(op),
            (m_phase == 5) ? 1 : (m_phase == 6) ? 2 : 0);
    end
  end

  task automatic settle_final(int exp_op, int exp_cke);
    for (int i = 0; i < 12; i++) begin
      done_i = i[0];
      pre_i  = 12'(i);
      skip_i = 2'(i);
      @(negedge clk);
    end
    done_i = 0;
    check("R10", "final op", int'(op), exp_op);
    check("R10", "final cke", int'(cke), exp_cke);
  endtask

  task automatic run_case(int pre, int post, logic [1:0] skip, int lag, bit scramble);
    int k;
    int pw, qw;
    rst_n  = 0;
    pre_i  = 12'(pre);
    post_i = 10'(post);
    skip_i = skip;
    done_i = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset cke", int'(cke), 0);
    check("R1", "reset start", int'(start), 0);
    check("R1", "reset op", int'(op), 0);
    rst_n = 1;
    pw = (pre == 0) ? 1 : pre * 1024;
    qw = (post == 0) ? 1 : post * 1024;
    if (skip == 2'b01) begin
      @(negedge clk);
      check("R8", "skip normal op", int'(op), 1);
      check("R8", "skip normal cke", int'(cke), 1);
      check("R8", "skip normal start", int'(start), 0);
      settle_final(1, 1);
      return;
    end
    if (skip == 2'b11) begin
      @(negedge clk);
      check("R9", "skip sref op", int'(op), 2);
      check("R9", "skip sref cke", int'(cke), 0);
      settle_final(2, 0);
      return;
    end
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        done_i = 1;  // early acknowledge, must be ignored (R7)
        if (scramble) begin
          pre_i  = 12'd0;
          post_i = 10'd7;
          skip_i = 2'b01;  // must not redirect (R2)
        end
      end else begin
        done_i = 0;
      end
    end while (!cke && k < 300000);
    check(scramble ? "R2" : "R4", "cke rise sample", k, 1 + pw);
    do begin
      @(negedge clk);
      k++;
    end while (!start && k < 300000);
    check("R5", "start sample", k, 1 + pw + qw);
    @(negedge clk);
    check("R6", "start width", int'(start), 0);
    for (int i = 0; i < lag; i++) begin
      @(negedge clk);
      check("R7", "op before ack", int'(op), 0);
    end
    done_i = 1;
    @(negedge clk);
    done_i = 0;
    check("R7", "op after ack", int'(op), 1);
    check("R7", "cke after ack", int'(cke), 1);
    settle_final(1, 1);
  endtask

  initial begin
    rst_n  = 0;
    pre_i  = 0;
    post_i = 0;
    skip_i = 0;
    done_i = 0;
    cmp_en = 1;
    run_case(78, 2, 2'b01, 0, 0);
    run_case(78, 2, 2'b11, 0, 0);
    run_case(0, 0, 2'b00, 0, 0);
    run_case(2, 1, 2'b10, 3, 0);
    run_case(3, 2, 2'b00, 5, 1);
    run_case(1, 0, 2'b00, 0, 0);
    run_case(0, 3, 2'b10, 1, 1);
    run_case(78, 2, 2'b00, 2, 0);
    cmp_en = 0;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule